// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block turns single CPU transfer requests into timed read and write cycles on an external memory bus. The CPU side offers a request with address, write data, a two-bit byte enable and a direction flag, and holds it until the block returns a one-clock acknowledge. On the memory side the block drives an address-latch strobe, a read strobe, low and high write strobes, a chip select, a separate address bus and a shared 16-bit data bus with its own output enable. It also samples a READY input. Every state of the sequence lasts one clock.

A 16-bit configuration register sets the shape of each cycle at run time. Its fields set the data-phase wait states, READY termination and polarity, an optional idle clock between address latch and strobe, a longer address latch, a recovery clock after the cycle, and the bus width and multiplexing. They also say whether the chip select spans the whole cycle or only the strobe. When the bus is disabled, requests are acknowledged with an error flag and no pin moves. All external strobes and the chip select are active high at the ports.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the configuration reads 0000h, so the bus is disabled. Until a configuration write, every request is answered with ack and err, and ALE, RD, WRL, WRH, CS and the data output enable stay low.
- R2: With bit 10 (bus enable) at 0, a request accepted in idle gets `ack_o` and `err_o` high together for exactly one clock, one clock after acceptance. No external pin is driven.
- R3: With READY disabled (bit 12 = 0), the strobe stays high for 16 minus the value in bits [3:0] clocks. 0000 gives 16 clocks and 1111 gives 1 clock.
- R4: With bit 4 at 0, one clock with every strobe low separates the fall of ALE from the strobe. With bit 4 at 1, the strobe starts in the clock after ALE falls.
- R5: With bit 5 at 0, one recovery clock follows the acknowledge. A request present during that clock is accepted only in the following clock. With bit 5 at 1, a request can be accepted in the clock right after the acknowledge.
- R6: ALE is high for two clocks when bit 9 is 1 and for one clock when it is 0. It rises one clock after the request is accepted.
- R7: Bits [7:6] select the bus: 00 is 8-bit separate, 01 is 8-bit shared, 10 is 16-bit separate, 11 is 16-bit shared. In shared modes `ad_o` carries address bits [15:0] with the output enable high during ALE. In separate modes the output enable is low during ALE. In every mode the enable is high after ALE only for writes.
- R8: In 16-bit modes, WRL follows byte enable bit 0 and WRH follows bit 1, and `ad_o` carries the full write word. In 8-bit modes only WRL pulses, and `ad_o[7:0]` carries the high byte when the byte enable is 10 and the low byte otherwise. RD and a write strobe are never high together.
- R9: With bit 12 at 1, READY passes through a two-flop synchronizer. The strobe ends only when the programmed wait states have elapsed and the synchronized READY equals bit 13 (1 means high ends the cycle, 0 means low).
- R10: When the enable for the current direction is 1 (bit 14 for reads, bit 15 for writes), CS is high only while the strobe is high. When it is 0, CS is high from the first ALE clock to the last strobe clock.
- R11: `ack_o` is high for exactly one clock, in the clock after the last strobe clock. For a read, `rdata_o` then holds the data bus value sampled in the last strobe clock: all 16 bits in 16-bit modes, and `ad_i[7:0]` copied into both bytes in 8-bit modes.
- R12: `addr_o` holds the accepted address from the first ALE clock through the last strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 16 | Configuration write value |
| req_i | input | 1 | CPU transfer request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Transfer address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| ack_o | output | 1 | One-clock transfer acknowledge |
| err_o | output | 1 | Request refused (bus disabled), valid with ack |
| rdata_o | output | 16 | Read data, valid with ack |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe |
| wrl_o | output | 1 | Low byte (or 8-bit) write strobe |
| wrh_o | output | 1 | High byte write strobe |
| cs_o | output | 1 | Chip select |
| addr_o | output | ADDR_W | External address bus |
| ad_o | output | 16 | Data bus / shared address-data output value |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 16 | Data bus input |
| ready_i | input | 1 | Asynchronous READY from the external device |

## Verification
The assertions assume that the configuration register is written only while no cycle is in progress, because the shaping fields are read live. They also assume that a request and its attributes stay stable from the moment the request is raised until ack. The stimulus writes the configuration only in idle, separated from any cycle, and drops the request only in the acknowledge clock. For each READY test, the bench holds READY at its inactive level for at least two clocks before the strobe, then switches it to the active level at a chosen strobe clock. This keeps the expected strobe length determinate through the synchronizer.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LATCH  = 3'd1,
    ST_LATCHX = 3'd2,
    ST_GAP    = 3'd3,
    ST_STROBE = 3'd4,
    ST_ACK    = 3'd5,
    ST_RECOV  = 3'd6,
    ST_REFUSE = 3'd7
  } seq_state_t;

  // Packed MSB first so that the struct maps bits 15..0 of the register.
  typedef struct packed {
    logic       cs_gate_wr;  // 15
    logic       cs_gate_rd;  // 14
    logic       rdy_pol;     // 13
    logic       rdy_en;      // 12
    logic       spare_b;     // 11
    logic       bus_on;      // 10
    logic       ale_long;    // 9
    logic       spare_a;     // 8
    logic       wide;        // 7  : 16-bit bus
    logic       shared;      // 6  : address/data shared
    logic       no_recov;    // 5
    logic       no_gap;      // 4
    logic [3:0] wait_code;   // 3:0 : waits = 15 - code
  } bus_cfg_t;

endpackage

// File: rtl/ext_bus_rdy_sync.sv
module ext_bus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[g] <= 1'b0;
      end else if (g == 0) begin
        chain_q[g] <= async_i;
      end else begin
        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_bus_wait_cnt.sv
module ext_bus_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: a counter that is not yet empty never jumps to empty without loading
  p_no_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i && (cnt_q > 4'(1))) |=> !zero_o);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [15:0]       rdata_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wrl_o,
  output logic              wrh_o,
  output logic              cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       ad_o,
  output logic              ad_oe_o,
  input  logic [15:0]       ad_i,
  input  logic              ready_i
);
  localparam int CNT_W  = 4;
  localparam int BYTE_W = 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bus_cfg_t   cfg_q;
  seq_state_t st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0] wdata_q, rdata_q;
  logic [1:0]  be_q;
  logic        we_q;
  logic        wait_zero, rdy_sync, rdy_ok, accept, cnt_load, cap_rd;

  // configuration register
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= bus_cfg_t'(cfg_wdata_i);
  end

  ext_bus_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk_i (clk_i), .rst_ni(rst_n), .async_i(ready_i), .sync_o(rdy_sync)
  );

  assign rdy_ok   = !cfg_q.rdy_en || (rdy_sync == cfg_q.rdy_pol);
  assign cnt_load = (st_d == ST_STROBE) && (st_q != ST_STROBE);

  ext_bus_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(cnt_load),
    .load_val_i(~cfg_q.wait_code), .dec_i(st_q == ST_STROBE),
    .zero_o(wait_zero)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = cfg_q.bus_on ? ST_LATCH : ST_REFUSE;
      ST_LATCH:  st_d = cfg_q.ale_long ? ST_LATCHX
                      : (cfg_q.no_gap ? ST_STROBE : ST_GAP);
      ST_LATCHX: st_d = cfg_q.no_gap ? ST_STROBE : ST_GAP;
      ST_GAP:    st_d = ST_STROBE;
      ST_STROBE: if (wait_zero && rdy_ok) st_d = ST_ACK;
      ST_ACK:    st_d = cfg_q.no_recov ? ST_IDLE : ST_RECOV;
      ST_RECOV:  st_d = ST_IDLE;
      ST_REFUSE: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request capture and read data capture
  assign accept = (st_q == ST_IDLE) && req_i && cfg_q.bus_on;
  assign cap_rd = (st_q == ST_STROBE) && (st_d == ST_ACK) && !we_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; wdata_q <= '0; be_q <= '0; we_q <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_i; wdata_q <= wdata_i; be_q <= be_i; we_q <= we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= cfg_q.wide ? ad_i : {2{ad_i[BYTE_W-1:0]}};
  end

  // pin decode
  logic in_latch, in_gap, in_strobe, in_cycle, cs_gated;
  logic [BYTE_W-1:0] narrow_byte;

  assign in_latch  = (st_q == ST_LATCH) || (st_q == ST_LATCHX);
  assign in_gap    = (st_q == ST_GAP);
  assign in_strobe = (st_q == ST_STROBE);
  assign in_cycle  = in_latch || in_gap || in_strobe;
  assign cs_gated  = we_q ? cfg_q.cs_gate_wr : cfg_q.cs_gate_rd;
  assign narrow_byte = (be_q == 2'b10) ? wdata_q[15:BYTE_W] : wdata_q[BYTE_W-1:0];

  assign ale_o   = in_latch;
  assign rd_o    = in_strobe && !we_q;
  assign wrl_o   = in_strobe && we_q && (!cfg_q.wide || be_q[0]);
  assign wrh_o   = in_strobe && we_q && cfg_q.wide && be_q[1];
  assign cs_o    = cs_gated ? in_strobe : in_cycle;
  assign addr_o  = addr_q;
  assign ad_oe_o = (cfg_q.shared && in_latch) || ((in_gap || in_strobe) && we_q);
  assign ad_o    = (cfg_q.shared && in_latch) ? addr_q[15:0]
                 : (cfg_q.wide ? wdata_q : {{BYTE_W{1'b0}}, narrow_byte});
  assign ack_o   = (st_q == ST_ACK) || (st_q == ST_REFUSE);
  assign err_o   = (st_q == ST_REFUSE);
  assign rdata_o = rdata_q;

  // assertions
  p_refuse_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_IDLE && req_i && !cfg_q.bus_on) |=> (ack_o && err_o && !ale_o && !cs_o));
  p_wait_min_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_strobe && !wait_zero) |=> in_strobe);
  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(ale_o) && !cfg_q.no_gap) |-> !(rd_o || wrl_o || wrh_o));
  p_recov_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RECOV) |=> (st_q == ST_IDLE && !ale_o));
  p_ale_long_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(ale_o) && cfg_q.ale_long) |-> $past(ale_o, 2));
  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rd_o && (wrl_o || wrh_o)));
  p_ready_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_strobe && cfg_q.rdy_en && (rdy_sync != cfg_q.rdy_pol)) |=> in_strobe);
  p_cs_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cs_o && cs_gated) |-> (rd_o || wrl_o || wrh_o));
  p_ack_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_o |=> !ack_o);
  p_addr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_cycle && $past(in_cycle)) |-> $stable(addr_o));
endmodule

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req = 1'b0, we = 1'b0, ready = 1'b0;
  logic [15:0] cfg_wdata = '0, wdata = '0, ad_in = '0;
  logic [AW-1:0] addr = '0;
  logic [1:0] be = '0;
  logic ack, err, ale, rd, wrl, wrh, cs, ad_oe;
  logic [15:0] rdata, ad_out;
  logic [AW-1:0] addr_out;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [15:0] cur_cfg = '0;
  int pend_recov = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .ack_o(ack), .err_o(err), .rdata_o(rdata), .ale_o(ale), .rd_o(rd),
    .wrl_o(wrl), .wrh_o(wrh), .cs_o(cs), .addr_o(addr_out), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .ad_i(ad_in), .ready_i(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input int wcode, input bit no_gap, input bit no_rec,
      input int btyp, input bit ale_long, input bit on, input bit ren, input bit pol,
      input bit csr, input bit csw);
    logic [15:0] c = '0;
    c[3:0] = 4'(wcode); c[4] = no_gap; c[5] = no_rec; c[7:6] = 2'(btyp);
    c[9] = ale_long; c[10] = on; c[12] = ren; c[13] = pol; c[14] = csr; c[15] = csw;
    return c;
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
    cur_cfg = v; pend_recov = 0;
  endtask

  // Behavioural reference: phase lengths computed from the configuration fields,
  // then every output compared on every clock of the transfer.
  task automatic xfer(input string tag, input bit w, input logic [AW-1:0] a,
      input logic [15:0] wd, input logic [1:0] b, input int rdy_k, input logic [15:0] adv);
    bit refused = !cur_cfg[10];
    int waits = 15 - int'(cur_cfg[3:0]);
    int ale_n = cur_cfg[9] ? 2 : 1;
    int gap_n = cur_cfg[4] ? 0 : 1;
    bit shared = cur_cfg[6], wide = cur_cfg[7], pol = cur_cfg[13], ren = cur_cfg[12];
    bit gated = w ? cur_cfg[15] : cur_cfg[14];
    int a0 = 1 + pend_recov;
    int s0 = a0 + ale_n + gap_n;
    int len = (!ren || rdy_k < 0) ? waits + 1 : ((waits > rdy_k + 2) ? waits : rdy_k + 2) + 1;
    int ack_t = refused ? a0 : s0 + len;
    req = 1'b1; we = w; addr = a; wdata = wd; be = b; ad_in = adv;
    ready = (ren && rdy_k < 0) ? pol : !pol;
    for (int t = 0; t <= ack_t; t++) begin
      bit e_ale, e_gap, e_stb, e_cyc, e_oe;
      logic [7:0] e_vec;
      logic [15:0] e_ad;
      if (t > 0) @(negedge clk);
      if (ren && rdy_k >= 0 && t == s0 + rdy_k) ready = pol;
      e_ale = !refused && t >= a0 && t < a0 + ale_n;
      e_gap = !refused && gap_n == 1 && t == a0 + ale_n;
      e_stb = !refused && t >= s0 && t < s0 + len;
      e_cyc = !refused && t >= a0 && t < s0 + len;
      e_oe  = (shared && e_ale) || ((e_gap || e_stb) && w);
      // {ack, err, ale, rd, wrl, wrh, cs, oe}
      e_vec = {t == ack_t, refused && t == ack_t, e_ale, e_stb && !w,
               e_stb && w && (!wide || b[0]), e_stb && w && wide && b[1],
               gated ? e_stb : e_cyc, e_oe};
      check({tag, " pins"}, {24'h0, ack, err, ale, rd, wrl, wrh, cs, ad_oe}, {24'h0, e_vec});
      if (e_oe) begin
        e_ad = (shared && e_ale) ? a[15:0]
             : (wide ? wd : {8'h00, (b == 2'b10) ? wd[15:8] : wd[7:0]});
        check({tag, " R7 R8 ad_o"}, {16'h0, ad_out}, {16'h0, e_ad});
      end
      if (e_cyc) check({tag, " R12 addr_o"}, {8'h0, addr_out}, {8'h0, a});
      if (t == ack_t && !refused && !w)
        check({tag, " R11 rdata"}, {16'h0, rdata}, {16'h0, wide ? adv : {2{adv[7:0]}}});
      if (t == ack_t) req = 1'b0;
    end
    @(negedge clk);
    pend_recov = (!refused && !cur_cfg[5]) ? 1 : 0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state, pins idle
    check("R1 idle pins", {24'h0, ack, err, ale, rd, wrl, wrh, cs, ad_oe}, 32'h0);
    xfer("R1 R2 reset refuse", 1'b1, 24'h001234, 16'hBEEF, 2'b11, -1, 16'h0);
    // R2: explicitly disabled with other fields set
    write_cfg(mk_cfg(15, 1, 1, 3, 1, 0, 0, 0, 1, 1));
    xfer("R2 disabled read", 1'b0, 24'h000010, 16'h0, 2'b11, -1, 16'h5A5A);
    // R3 R4 R5: 16-bit separate, no waits, no gap, no recovery
    write_cfg(mk_cfg(15, 1, 1, 2, 0, 1, 0, 0, 0, 0));
    xfer("R3 R4 R8 w16 word", 1'b1, 24'hABCDEF, 16'h1357, 2'b11, -1, 16'h0);
    xfer("R5 R11 back-to-back read", 1'b0, 24'h012345, 16'h0, 2'b11, -1, 16'hC3A5);
    // R3 R4 R5 R7: 3 waits, gap on, recovery on, 16-bit shared
    write_cfg(mk_cfg(12, 0, 0, 3, 0, 1, 0, 0, 0, 0));
    xfer("R7 R8 shared low byte", 1'b1, 24'h00F00D, 16'hA1B2, 2'b01, -1, 16'h0);
    xfer("R5 R8 after recov high byte", 1'b1, 24'h00BEEF, 16'hC4D5, 2'b10, -1, 16'h0);
    xfer("R7 R11 shared read", 1'b0, 24'h004242, 16'h0, 2'b11, -1, 16'h9876);
    // R3: maximum waits (code 0000)
    write_cfg(mk_cfg(0, 1, 1, 2, 0, 1, 0, 0, 0, 0));
    xfer("R3 fifteen waits", 1'b0, 24'h000100, 16'h0, 2'b11, -1, 16'h1111);
    // R6 R8: 8-bit shared with long ALE, byte lanes
    write_cfg(mk_cfg(14, 1, 1, 1, 1, 1, 0, 0, 0, 0));
    xfer("R6 R8 narrow high byte", 1'b1, 24'h000777, 16'hE1F2, 2'b10, -1, 16'h0);
    xfer("R6 R8 narrow low byte", 1'b1, 24'h000778, 16'hE1F2, 2'b01, -1, 16'h0);
    xfer("R6 R11 narrow read", 1'b0, 24'h000779, 16'h0, 2'b01, -1, 16'h77AB);
    // R7: 8-bit separate
    write_cfg(mk_cfg(13, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    xfer("R7 R8 narrow separate write", 1'b1, 24'h000333, 16'h0F5A, 2'b11, -1, 16'h0);
    xfer("R7 R11 narrow separate read", 1'b0, 24'h000334, 16'h0, 2'b11, -1, 16'h4C3D);
    // R10: chip select gating per direction
    write_cfg(mk_cfg(13, 0, 1, 2, 1, 1, 0, 0, 1, 0));
    xfer("R10 read gated", 1'b0, 24'h000500, 16'h0, 2'b11, -1, 16'h2468);
    xfer("R10 write whole", 1'b1, 24'h000501, 16'h1234, 2'b11, -1, 16'h0);
    write_cfg(mk_cfg(13, 0, 1, 2, 1, 1, 0, 0, 0, 1));
    xfer("R10 read whole", 1'b0, 24'h000502, 16'h0, 2'b11, -1, 16'h3579);
    xfer("R10 write gated", 1'b1, 24'h000503, 16'h8642, 2'b11, -1, 16'h0);
    // R9: READY termination, both polarities
    write_cfg(mk_cfg(13, 1, 1, 2, 0, 1, 1, 1, 0, 0));
    xfer("R9 high active late", 1'b0, 24'h000900, 16'h0, 2'b11, 6, 16'hAAAA);
    xfer("R9 high active early", 1'b1, 24'h000901, 16'h5555, 2'b11, 0, 16'h0);
    xfer("R9 high active preset", 1'b0, 24'h000902, 16'h0, 2'b11, -1, 16'h0F0F);
    write_cfg(mk_cfg(10, 0, 0, 3, 0, 1, 1, 0, 0, 0));
    xfer("R9 low active late", 1'b1, 24'h000A00, 16'h7E7E, 2'b11, 9, 16'h0);
    xfer("R9 low active preset", 1'b0, 24'h000A01, 16'h0, 2'b11, -1, 16'hF00F);
    // R9: READY ignored when disabled
    write_cfg(mk_cfg(12, 1, 1, 2, 0, 1, 0, 1, 0, 0));
    xfer("R9 R3 ready ignored", 1'b0, 24'h000B00, 16'h0, 2'b11, 0, 16'h6161);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule